// File: doc/BRIEF.md
# Virtually indexed, physically tagged read cache

This block is a read-only data cache for a CPU load path. The set index and the line offset are taken only from the low address bits that translation leaves unchanged. The tag and line arrays can therefore be read at the same clock edge as the translation buffer lookup. In the next cycle the stored physical tags are compared with the frame number that the translation buffer returned, and the selected word goes back to the CPU. A hit costs one cycle, where doing translation first and the cache access after it would cost two.

Translation uses a small, fully associative buffer. A separate write port loads entries into it. A write to a page number that is already present replaces that entry in place; any other write fills the slot named by a rotating pointer. An access whose page is not in the buffer returns at once with a translation-miss flag and no data.

On a line miss the cache stalls the CPU and asks memory for the whole line by physical address. It writes the returned line into the victim way of the set and then reruns the access. Each set keeps one bit that names the way to replace next. The default geometry is 4 KB pages, 8 KB of capacity, 2 ways and 16-byte lines, so the index plus the offset fill the page offset exactly. Elaboration stops if a geometry would need translated bits for the index.

Top module: `vipt_cache`

## Requirements
- R1: While reset is held and in the cycle after it ends, `cpu_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every line starts invalid, so the first access to any mapped address is a line miss.
- R2: A request accepted (`cpu_req` and `cpu_ready` both 1 at a clock edge) that translates and hits in the cache raises `rsp_valid` in the cycle that follows. It has `rsp_tlb_miss` = 0, the correct word on `rsp_data`, and no memory request.
- R3: The hit test compares the physical frame number from the translation buffer, not the virtual page bits. Two virtual pages mapped to one frame share the cached line. Two frames that share a page offset fall in the same set but do not hit each other.
- R4: An accepted request whose virtual page (address bits 31:12) has no valid buffer entry answers in the next cycle with `rsp_valid` = 1, `rsp_tlb_miss` = 1 and `rsp_data` = 0, and starts no memory request.
- R5: The translation buffer has 4 entries. A write whose page number matches a valid entry overwrites that entry's frame and leaves the rotating pointer where it is. Any other write fills the slot under the pointer (0, 1, 2, 3, 0, ...) and advances it, evicting the oldest such fill.
- R6: On a translated line miss, `mem_req` rises one cycle after the miss is seen. It holds, with `mem_paddr` = {frame, address bits 11:4, 4'b0000} kept stable, until `mem_rsp_valid`. `cpu_ready` and `rsp_valid` stay 0 meanwhile.
- R7: Two cycles after the edge where `mem_rsp_valid` is taken, `rsp_valid` rises with the requested word from the refilled line.
- R8: Word k of a line is `mem_rsp_line[32k+31:32k]`, and address bits 3:2 choose k.
- R9: Each set has one replacement bit. Any hit or refill in a set marks the other way as the next victim, and a refill goes into the marked way. The bit resets to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, taken when `cpu_ready` is 1 |
| cpu_vaddr | input | 32 | Virtual byte address of the word |
| cpu_ready | output | 1 | Cache can take a request this cycle |
| rsp_valid | output | 1 | Response for the last taken request |
| rsp_tlb_miss | output | 1 | Response carries no data: page not mapped |
| rsp_data | output | 32 | Word read, zero on a translation miss |
| tlb_wr_en | input | 1 | Install a translation entry |
| tlb_wr_vpn | input | 20 | Virtual page number to install |
| tlb_wr_pfn | input | 20 | Physical frame number for that page |
| mem_req | output | 1 | Line refill request, held until answered |
| mem_paddr | output | 32 | Line-aligned physical address of the refill |
| mem_rsp_valid | input | 1 | Refill data is present this cycle |
| mem_rsp_line | input | 128 | Refill line, word 0 in the low bits |

## Verification
The bench maps several virtual pages onto a handful of frames so that aliases and same-set conflicts occur often. A design that compared virtual page bits would miss on the alias of a cached line, and one that ignored the frame would return another frame's data. Directed runs fill, touch and evict within one set to expose a replacement bit that is never updated on hits, and they overflow the translation buffer to catch a pointer that moves on an in-place rewrite. Miss latency is measured against the memory delay, which catches a replay that comes back early with stale data or never comes back, and unmapped pages check that a translation miss neither returns data nor reaches memory.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [1:0] {
        CTL_LOOKUP = 2'd0,
        CTL_FILL   = 2'd1,
        CTL_REPLAY = 2'd2
    } ctl_state_e;

    // width of an index over n items, never below one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PFN_W   = 20,
    parameter int unsigned ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn
);
    localparam int unsigned PTR_W = vipt_pkg::idx_bits(ENTRIES);

    logic [ENTRIES-1:0] ent_valid;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn [ENTRIES];
    logic [PTR_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [PTR_W-1:0]   wr_slot;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign lk_match[e] = ent_valid[e] && (ent_vpn[e] == lk_vpn);
        assign wr_match[e] = ent_valid[e] && (ent_vpn[e] == wr_vpn);
    end

    always_comb begin
        lk_pfn = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (lk_match[e]) lk_pfn = lk_pfn | ent_pfn[e];
    end
    assign lk_hit = |lk_match;

    always_comb begin
        wr_slot = rr_ptr;
        for (int e = 0; e < ENTRIES; e++)
            if (wr_match[e]) wr_slot = PTR_W'(e);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            rr_ptr    <= '0;
        end else if (wr_en) begin
            ent_valid[wr_slot] <= 1'b1;
            if (!(|wr_match))
                rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_vpn[wr_slot] <= wr_vpn;
            ent_pfn[wr_slot] <= wr_pfn;
        end
    end
endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
    parameter int unsigned SETS   = 256,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned TAG_W  = 20,
    parameter int unsigned LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [SETS-1:0]   vld;
    logic [TAG_W-1:0]  tags  [SETS];
    logic [LINE_W-1:0] lines [SETS];

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx]  <= wr_tag;
            lines[wr_idx] <= wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else if (rd_en) rd_valid <= vld[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag  <= tags[rd_idx];
            rd_line <= lines[rd_idx];
        end
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int unsigned VA_W        = 32,
    parameter int unsigned PA_W        = 32,
    parameter int unsigned PAGE_BYTES  = 4096,
    parameter int unsigned CACHE_BYTES = 8192,
    parameter int unsigned WAYS        = 2,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned TLB_ENTRIES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cpu_req,
    input  logic [VA_W-1:0]                   cpu_vaddr,
    output logic                              cpu_ready,
    output logic                              rsp_valid,
    output logic                              rsp_tlb_miss,
    output logic [31:0]                       rsp_data,
    input  logic                              tlb_wr_en,
    input  logic [VA_W-$clog2(PAGE_BYTES)-1:0] tlb_wr_vpn,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0] tlb_wr_pfn,
    output logic                              mem_req,
    output logic [PA_W-1:0]                   mem_paddr,
    input  logic                              mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]           mem_rsp_line
);
    import vipt_pkg::*;

    localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned SETS   = CACHE_BYTES / (WAYS * LINE_BYTES);
    localparam int unsigned IDX_W  = idx_bits(SETS);
    localparam int unsigned VPN_W  = VA_W - PAGE_W;
    localparam int unsigned PFN_W  = PA_W - PAGE_W;
    localparam int unsigned TAG_W  = PA_W - IDX_W - OFF_W;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned SEL_W  = idx_bits(LINE_BYTES / 4);
    localparam int unsigned WAY_W  = idx_bits(WAYS);

    if (IDX_W + OFF_W > PAGE_W) begin : g_index_beyond_page
        $error("cache index and line offset must fit inside the page offset");
    end
    if (WAYS > 2) begin : g_too_many_ways
        $error("one replacement bit per set supports at most two ways");
    end

    ctl_state_e         state;
    logic               s1_valid;
    logic [VA_W-1:0]    s1_vaddr;
    logic               s1_tlb_hit;
    logic [PFN_W-1:0]   s1_pfn;
    logic [PA_W-1:0]    fill_paddr;
    logic [SETS-1:0]    lru;

    logic               lookup;
    logic [VA_W-1:0]    lk_vaddr;
    logic               tlb_hit;
    logic [PFN_W-1:0]   tlb_pfn;

    logic [WAYS-1:0]    way_vld;
    logic [TAG_W-1:0]   way_tag  [WAYS];
    logic [LINE_W-1:0]  way_line [WAYS];
    logic [WAYS-1:0]    way_hit;

    logic [PA_W-1:0]    s1_paddr;
    logic [TAG_W-1:0]   s1_tag;
    logic [IDX_W-1:0]   s1_idx;
    logic               any_hit;
    logic [WAY_W-1:0]   hit_way;
    logic [LINE_W-1:0]  hit_line;
    logic [31:0]        hit_word;
    logic               line_miss;
    logic               fill_we;
    logic [WAY_W-1:0]   victim;

    // stage one: translation and array read run from the same untranslated index
    assign lookup   = (cpu_req && cpu_ready) || (state == CTL_REPLAY);
    assign lk_vaddr = (state == CTL_REPLAY) ? s1_vaddr : cpu_vaddr;

    vipt_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk    (clk),
        .rst    (rst),
        .lk_vpn (lk_vaddr[VA_W-1:PAGE_W]),
        .lk_hit (tlb_hit),
        .lk_pfn (tlb_pfn),
        .wr_en  (tlb_wr_en),
        .wr_vpn (tlb_wr_vpn),
        .wr_pfn (tlb_wr_pfn)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .rd_en    (lookup),
            .rd_idx   (lk_vaddr[OFF_W +: IDX_W]),
            .rd_valid (way_vld[w]),
            .rd_tag   (way_tag[w]),
            .rd_line  (way_line[w]),
            .wr_en    (fill_we && (victim == WAY_W'(w))),
            .wr_idx   (s1_idx),
            .wr_tag   (s1_tag),
            .wr_line  (mem_rsp_line)
        );
        assign way_hit[w] = way_vld[w] && (way_tag[w] == s1_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_tlb_hit <= 1'b0;
        end else begin
            s1_valid <= lookup;
            if (lookup) s1_tlb_hit <= tlb_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (lookup) begin
            s1_vaddr <= lk_vaddr;
            s1_pfn   <= tlb_pfn;
        end
    end

    // stage two: physical tag compare and word select
    assign s1_paddr = {s1_pfn, s1_vaddr[PAGE_W-1:0]};
    assign s1_tag   = s1_paddr[PA_W-1 -: TAG_W];
    assign s1_idx   = s1_vaddr[OFF_W +: IDX_W];

    always_comb begin
        any_hit  = 1'b0;
        hit_way  = '0;
        hit_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                any_hit  = 1'b1;
                hit_way  = WAY_W'(w);
                hit_line = way_line[w];
            end
        end
    end

    assign hit_word     = hit_line[{s1_vaddr[2 +: SEL_W], 5'b00000} +: 32];
    assign line_miss    = s1_valid && s1_tlb_hit && !any_hit;
    assign rsp_valid    = s1_valid && (!s1_tlb_hit || any_hit);
    assign rsp_tlb_miss = s1_valid && !s1_tlb_hit;
    assign rsp_data     = (s1_valid && s1_tlb_hit && any_hit) ? hit_word : 32'd0;
    assign cpu_ready    = (state == CTL_LOOKUP) && !line_miss;

    // refill control
    assign fill_we   = (state == CTL_FILL) && mem_rsp_valid;
    assign mem_req   = (state == CTL_FILL);
    assign mem_paddr = fill_paddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CTL_LOOKUP;
            fill_paddr <= '0;
        end else begin
            unique case (state)
                CTL_LOOKUP: if (line_miss) begin
                    state      <= CTL_FILL;
                    fill_paddr <= {s1_paddr[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                end
                CTL_FILL:   if (mem_rsp_valid) state <= CTL_REPLAY;
                CTL_REPLAY: state <= CTL_LOOKUP;
                default:    state <= CTL_LOOKUP;
            endcase
        end
    end

    // replacement: one bit per set naming the next victim
    if (WAYS > 1) begin : g_lru
        assign victim = WAY_W'(lru[s1_idx]);
        always_ff @(posedge clk) begin
            if (rst) lru <= '0;
            else if (s1_valid && s1_tlb_hit && any_hit) lru[s1_idx] <= ~hit_way[0];
        end
    end else begin : g_direct
        assign victim = '0;
        assign lru    = '0;
    end
endmodule

// File: rtl/vipt_cache_checker.sv
module vipt_cache_checker #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned OFF_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            cpu_ready,
    input logic            rsp_valid,
    input logic            rsp_tlb_miss,
    input logic [31:0]     rsp_data,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_paddr,
    input logic            mem_rsp_valid
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (cpu_ready && !mem_req && !rsp_valid));

    a_r2_accept_answers: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready) |=> (rsp_valid || !cpu_ready));

    a_r4_tlb_miss_no_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_tlb_miss) |-> (rsp_data == 32'd0));

    a_r6_request_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_paddr)));

    a_r6_line_aligned_stall: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_paddr[OFF_W-1:0] == '0 && !cpu_ready && !rsp_valid));

    a_r7_replay_answers: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rsp_valid) |=> ##1 (rsp_valid && !rsp_tlb_miss));
endmodule

bind vipt_cache vipt_cache_checker #(.PA_W(PA_W), .OFF_W(OFF_W)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .cpu_req       (cpu_req),
    .cpu_ready     (cpu_ready),
    .rsp_valid     (rsp_valid),
    .rsp_tlb_miss  (rsp_tlb_miss),
    .rsp_data      (rsp_data),
    .mem_req       (mem_req),
    .mem_paddr     (mem_paddr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
    localparam int SETS    = 256;
    localparam int MEM_DLY = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0;
    logic [31:0]  cpu_vaddr = '0;
    logic         cpu_ready, rsp_valid, rsp_tlb_miss;
    logic [31:0]  rsp_data;
    logic         tlb_wr_en = 1'b0;
    logic [19:0]  tlb_wr_vpn = '0, tlb_wr_pfn = '0;
    logic         mem_req;
    logic [31:0]  mem_paddr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_line = '0;

    int checks = 0;
    int fails  = 0;
    int fills  = 0;
    logic [31:0] last_req;

    // translation model
    logic        tv   [4];
    logic [19:0] tvpn [4];
    logic [19:0] tpfn [4];
    int          trr;
    // cache model
    logic        mv  [SETS][2];
    logic [19:0] mt  [SETS][2];
    logic        mlru[SETS];

    vipt_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_vaddr(cpu_vaddr),
        .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_tlb_miss(rsp_tlb_miss),
        .rsp_data(rsp_data), .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn),
        .tlb_wr_pfn(tlb_wr_pfn), .mem_req(mem_req), .mem_paddr(mem_paddr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5EED_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory: answers each refill after MEM_DLY cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_rsp_valid) begin
                fills++;
                last_req = mem_paddr;
                repeat (MEM_DLY) @(negedge clk);
                for (int k = 0; k < 4; k++)
                    mem_rsp_line[32*k +: 32] = mem_word(last_req + 32'(4 * k));
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic tlb_write(input logic [19:0] vpn, input logic [19:0] pfn);
        int slot = -1;
        for (int e = 0; e < 4; e++) if (tv[e] && tvpn[e] == vpn) slot = e;
        if (slot < 0) begin
            slot = trr;
            trr  = (trr + 1) % 4;
        end
        tv[slot] = 1'b1; tvpn[slot] = vpn; tpfn[slot] = pfn;
        tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_pfn = pfn;
        @(negedge clk);
        tlb_wr_en = 1'b0;
    endtask

    task automatic do_access(input logic [31:0] va, input string req);
        int slot = -1;
        int hw = -1;
        int n;
        int f0;
        logic [31:0] pa, exp_word, exp_line;
        int set;
        for (int e = 0; e < 4; e++) if (tv[e] && tvpn[e] == va[31:12]) slot = e;
        while (!cpu_ready) @(negedge clk);
        f0 = fills;
        cpu_req = 1'b1; cpu_vaddr = va;
        @(negedge clk);
        cpu_req = 1'b0;
        if (slot < 0) begin
            // R4: unmapped page answers at once, flagged, zero data, no refill
            chk(rsp_valid && rsp_tlb_miss, req, "translation miss response",
                {30'd0, rsp_valid, rsp_tlb_miss}, 32'd3);
            chk(rsp_data == 0 && !mem_req, req, "no data or refill on translation miss",
                rsp_data, 32'd0);
            return;
        end
        pa       = {tpfn[slot], va[11:0]};
        set      = int'(pa[11:4]);
        exp_word = mem_word({pa[31:2], 2'b00});
        exp_line = {pa[31:4], 4'b0000};
        for (int w = 0; w < 2; w++) if (mv[set][w] && mt[set][w] == pa[31:12]) hw = w;
        if (hw >= 0) begin
            chk(rsp_valid && !rsp_tlb_miss, req, "hit answers next cycle (R2)",
                {31'd0, rsp_valid}, 32'd1);
            chk(rsp_data == exp_word, req, "hit word (R8)", rsp_data, exp_word);
            chk(fills == f0, req, "hit without refill", 32'(fills), 32'(f0));
            mlru[set] = (hw == 0);
        end else begin
            chk(!rsp_valid && !cpu_ready, req, "miss stalls (R6)",
                {30'd0, rsp_valid, cpu_ready}, 32'd0);
            n = 1;
            while (!rsp_valid && n < 40) begin
                if (mem_req && (mem_paddr != exp_line || cpu_ready))
                    chk(1'b0, req, "refill address held (R6)", mem_paddr, exp_line);
                @(negedge clk);
                n++;
            end
            chk(n == MEM_DLY + 4, req, "replay latency (R7)", 32'(n), 32'(MEM_DLY + 4));
            chk(fills == f0 + 1 && last_req == exp_line, req, "refill physical line (R6)",
                last_req, exp_line);
            chk(rsp_valid && !rsp_tlb_miss && rsp_data == exp_word, req,
                "replayed word (R7)", rsp_data, exp_word);
            hw = mlru[set] ? 1 : 0;
            mv[set][hw] = 1'b1;
            mt[set][hw] = pa[31:12];
            mlru[set]   = (hw == 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'd20250611));
        trr = 0;
        for (int e = 0; e < 4; e++) tv[e] = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            mv[s][0] = 1'b0; mv[s][1] = 1'b0; mlru[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready && !rsp_valid && !mem_req, "R1", "state during reset",
            {29'd0, cpu_ready, rsp_valid, mem_req}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready && !rsp_valid && !mem_req, "R1", "state after reset",
            {29'd0, cpu_ready, rsp_valid, mem_req}, 32'd4);

        tlb_write(20'h00010, 20'h00080);
        tlb_write(20'h00020, 20'h00080);
        tlb_write(20'h00030, 20'h00081);
        tlb_write(20'h00040, 20'h00082);

        do_access(32'h0001_0040, "R1");   // cold miss
        do_access(32'h0002_0044, "R3");   // alias of the same frame hits
        do_access(32'h0003_0040, "R3");   // same set, other frame misses
        do_access(32'h0001_0048, "R8");
        do_access(32'h0002_004C, "R8");
        do_access(32'h0001_0040, "R9");   // touch frame 0x80
        do_access(32'h0004_0040, "R9");   // evicts frame 0x81
        do_access(32'h0001_0044, "R9");   // still present
        do_access(32'h0003_0040, "R9");   // refetched
        do_access(32'h0005_0000, "R4");   // unmapped page

        tlb_write(20'h00050, 20'h00090);  // takes slot 0, drops page 0x10
        do_access(32'h0001_0040, "R5");
        do_access(32'h0002_0040, "R5");
        tlb_write(20'h00020, 20'h00091);  // rewrite in place
        do_access(32'h0002_0040, "R5");
        tlb_write(20'h00060, 20'h00092);  // pointer still at slot 1
        do_access(32'h0002_0040, "R5");
        do_access(32'h0006_0100, "R5");
        do_access(32'h0003_0104, "R5");

        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0)
                tlb_write(20'h00010 + 20'($urandom_range(0, 5)),
                          20'h00080 + 20'($urandom_range(0, 3)));
            va = {12'd0, 4'd1, 4'($urandom_range(0, 5)),
                  4'd0, 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b00};
            do_access(va, "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule